// File: doc/BRIEF.md
# Double-Buffered Disk Read DMA Engine

This block carries bytes from a disk controller's data register into word-wide memory without processor help. Whenever the controller raises its data-request line, the engine captures one byte into the active one of two 16-byte staging buffers. It does this only while a programmed byte budget is not yet used up and the request source is set to the floppy controller. When a buffer fills, the engine asks for the memory bus.

When the bus is granted, the engine bursts the full buffers to memory as big-endian 16-bit words at an auto-incrementing byte address. The older buffer goes first and the newer one follows if it is also full. The burst ends with a one-cycle completion pulse that reports how many words moved.

If a buffer fills while its partner still waits to be drained, a sticky error is raised and capture stalls until a burst empties both buffers. Only the disk-to-memory direction is handled. When the direction control selects disk writes, the engine idles. Any change of that control clears the capture state.

Top module: `dskdma_engine`

## Requirements
- R1: A byte is taken only at a rising edge of `fdc_drq`, so one assertion gives one byte however long it is held. It is taken only while the byte budget is nonzero, `ctl_drq_floppy` is 1 and `ctl_dir_write` is 0. Each taken byte lowers the budget by one. `sectors_left` shows the budget divided by 512, rounded up.
- R2: A `cnt_load` pulse sets the byte budget to `cnt_sectors` × 512, and `sectors_left` then shows `cnt_sectors`. After reset the budget is 0.
- R3: Taken bytes go to consecutive positions 0..15 of the active buffer. When position 15 is written, that buffer becomes full. If the other buffer is empty, filling moves to the other buffer at position 0.
- R4: If a buffer fills while the other is still full, `dma_err` goes to 1 and stays there. Capture then stalls: bytes taken during the stall are discarded, but they still lower the budget.
- R5: `bus_req` goes to 1 in the cycle after a buffer becomes full. It returns to 0 in the cycle after `bus_gnt` is seen.
- R6: On a grant, if the older (not active) buffer is full, it is written as 8 words. Word i holds byte 2i in bits 15:8 and byte 2i+1 in bits 7:0. The address starts at the loaded `addr_value` with bit 0 forced to 0 and rises by 2 after every word. The buffer is empty afterwards.
- R7: After the older buffer, the newer buffer is also written in the same way if it is full, giving 16 words. Filling of the stalled buffer then resumes at position 0.
- R8: If the older buffer is not full at the grant, no word is written and the burst reports 0 words. Bytes already in the active buffer are kept.
- R9: A word on `mem_valid` keeps its address and data until `mem_ready` is 1. At the end of each grant, `burst_done` pulses for one cycle, and `burst_words` (0, 8 or 16) is valid in that cycle.
- R10: A buffer freed by the final beat of a burst counts as empty for a buffer that fills in that same cycle. No error is raised, filling switches over, and a new request follows.
- R11: While `ctl_dir_write` is 1, no byte is taken, `bus_req` is never raised and grants are ignored. Any change of `ctl_dir_write` clears the fill position, the buffer selection, `dma_err` and the byte budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_dir_write | input | 1 | 1 selects disk-write direction (engine idles); a change clears capture state |
| ctl_drq_floppy | input | 1 | 1 selects the floppy controller as request source |
| cnt_load | input | 1 | Load pulse for the sector budget |
| cnt_sectors | input | 8 | Sector count to load |
| sectors_left | output | 8 | Remaining budget in sectors, rounded up |
| addr_load | input | 1 | Load pulse for the memory address |
| addr_value | input | 24 | Memory byte address to load (bit 0 ignored) |
| fdc_drq | input | 1 | Controller data request |
| fdc_data | input | 8 | Controller data register value |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_valid | output | 1 | Memory write word valid |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | 24 | Byte address of the word |
| mem_wdata | output | 16 | Big-endian word data |
| burst_done | output | 1 | One-cycle end-of-grant pulse |
| burst_words | output | 5 | Words written by the finished grant |
| dma_err | output | 1 | Sticky overrun flag |

## Verification
The two functions that can coincide are draining and capture. The final accepted beat of the older buffer clears its full flag in the same cycle that the sixteenth byte completes the other buffer. The bench holds `mem_ready` high, counts edges from the grant, and raises `fdc_drq` so that the capture edge lands exactly on the last beat. It judges the result by `dma_err` staying 0, `bus_req` rising again, and the following grant writing exactly the newly filled buffer's words at the next addresses.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_OLD,
        BS_NEW,
        BS_DONE
    } burst_state_e;

    typedef struct packed {
        logic [1:0] full;
        logic       active;
        logic       err;
    } fill_status_t;

    function automatic logic [15:0] be_word(input logic [7:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/dskdma_capture.sv
module dskdma_capture #(
    parameter int SECT_BITS  = 8,
    parameter int SECT_SHIFT = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 drq,
    input  logic                 drq_floppy,
    input  logic                 dir_write,
    input  logic                 cnt_load,
    input  logic [SECT_BITS-1:0] cnt_sectors,
    output logic                 take,
    output logic                 soft_clr,
    output logic [SECT_BITS-1:0] sectors_left
);
    localparam int CNT_W = SECT_BITS + SECT_SHIFT;

    logic             drq_q;
    logic             dir_q;
    logic [CNT_W-1:0] cnt;

    assign soft_clr = dir_write ^ dir_q;
    assign take     = drq & ~drq_q & (cnt != '0) & drq_floppy & ~dir_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            drq_q <= 1'b0;
            dir_q <= 1'b0;
            cnt   <= '0;
        end else begin
            drq_q <= drq;
            dir_q <= dir_write;
            if (soft_clr)
                cnt <= '0;
            else if (cnt_load)
                cnt <= {cnt_sectors, {SECT_SHIFT{1'b0}}};
            else if (take)
                cnt <= cnt - 1'b1;
        end
    end

    assign sectors_left = cnt[CNT_W-1:SECT_SHIFT] + SECT_BITS'(|cnt[SECT_SHIFT-1:0]);

    // R1
    one_take_per_drq_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !soft_clr && !cnt_load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dskdma_bufbank.sv
module dskdma_bufbank
    import dskdma_pkg::*;
#(
    parameter int BUF_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              take,
    input  logic [7:0]                        din,
    input  logic                              soft_clr,
    input  logic [1:0]                        clr_full,
    input  logic                              rd_buf,
    input  logic [$clog2(BUF_BYTES/2)-1:0]    rd_word,
    output fill_status_t                      status,
    output logic                              fill_evt,
    output logic [15:0]                       rd_data
);
    localparam int BW = $clog2(BUF_BYTES);
    localparam int IW = BW + 1;

    logic [7:0]    store [2][BUF_BYTES];
    logic [IW-1:0] idx, idx_n;
    logic [1:0]    full, full_n;
    logic          active, act_n;
    logic          err, err_n;
    logic          wr_en;

    always_comb begin
        full_n   = full & ~clr_full;
        idx_n    = idx;
        act_n    = active;
        err_n    = err;
        wr_en    = 1'b0;
        fill_evt = 1'b0;
        if (clr_full[active] && idx == IW'(BUF_BYTES))
            idx_n = '0;
        if (take && idx < IW'(BUF_BYTES)) begin
            wr_en = 1'b1;
            if (idx == IW'(BUF_BYTES - 1)) begin
                fill_evt       = 1'b1;
                full_n[active] = 1'b1;
                if (!full_n[~active]) begin
                    act_n = ~active;
                    idx_n = '0;
                end else begin
                    err_n = 1'b1;
                    idx_n = IW'(BUF_BYTES);
                end
            end else begin
                idx_n = idx + 1'b1;
            end
        end
        if (soft_clr) begin
            idx_n = '0;
            act_n = 1'b0;
            err_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= '0;
            idx    <= '0;
            active <= 1'b0;
            err    <= 1'b0;
        end else begin
            full   <= full_n;
            idx    <= idx_n;
            active <= act_n;
            err    <= err_n;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            store[active][idx[BW-1:0]] <= din;
    end

    assign rd_data = be_word(store[rd_buf][{rd_word, 1'b0}], store[rd_buf][{rd_word, 1'b1}]);
    assign status  = '{full: full, active: active, err: err};

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !soft_clr) |=> err);

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (full == 2'b11));

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= IW'(BUF_BYTES));

    // R3
    switch_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> ($past(fill_evt) || $past(soft_clr)));

endmodule

// File: rtl/dskdma_burst.sv
module dskdma_burst
    import dskdma_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUF_BYTES = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            gnt,
    input  logic                            enable,
    input  logic [1:0]                      full,
    input  logic                            active,
    input  logic                            addr_load,
    input  logic [ADDR_W-1:0]               addr_value,
    input  logic                            mem_ready,
    output logic                            mem_valid,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            rd_buf,
    output logic [$clog2(BUF_BYTES/2)-1:0]  rd_word,
    output logic [1:0]                      clr_full,
    output logic                            done,
    output logic [$clog2(BUF_BYTES+1)-1:0]  words
);
    localparam int WPB = BUF_BYTES / 2;
    localparam int WW  = $clog2(WPB);
    localparam int CW  = $clog2(BUF_BYTES + 1);

    burst_state_e  st;
    logic          cur;
    logic [WW-1:0] widx;
    logic [ADDR_W-1:0] addr;
    logic [CW-1:0] wcnt;
    logic          last, beat;

    assign last      = (widx == WW'(WPB - 1));
    assign mem_valid = (st == BS_OLD) || (st == BS_NEW);
    assign beat      = mem_valid & mem_ready;
    assign mem_addr  = addr;
    assign rd_buf    = cur;
    assign rd_word   = widx;
    assign done      = (st == BS_DONE);
    assign words     = wcnt;

    always_comb begin
        clr_full = '0;
        if (beat && last)
            clr_full[cur] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BS_IDLE;
            cur  <= 1'b0;
            widx <= '0;
            addr <= '0;
            wcnt <= '0;
        end else begin
            case (st)
                BS_IDLE: begin
                    if (gnt && enable) begin
                        if (full[~active]) begin
                            st   <= BS_OLD;
                            cur  <= ~active;
                            widx <= '0;
                        end else begin
                            st   <= BS_DONE;
                            wcnt <= '0;
                        end
                    end
                end
                BS_OLD: begin
                    if (beat) begin
                        addr <= addr + ADDR_W'(2);
                        widx <= widx + 1'b1;
                        if (last) begin
                            if (full[active]) begin
                                st   <= BS_NEW;
                                cur  <= active;
                                widx <= '0;
                            end else begin
                                st   <= BS_DONE;
                                wcnt <= CW'(WPB);
                            end
                        end
                    end
                end
                BS_NEW: begin
                    if (beat) begin
                        addr <= addr + ADDR_W'(2);
                        widx <= widx + 1'b1;
                        if (last) begin
                            st   <= BS_DONE;
                            wcnt <= CW'(BUF_BYTES);
                        end
                    end
                end
                default: st <= BS_IDLE;
            endcase
            if (addr_load)
                addr <= addr_value & ~ADDR_W'(1);
        end
    end

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && !addr_load) |=> (mem_valid && $stable(mem_addr) && $stable(rd_word)));

    // R6
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !mem_addr[0]);

    // R9
    done_words_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (words == '0 || words == CW'(WPB) || words == CW'(BUF_BYTES)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/dskdma_engine.sv
module dskdma_engine
    import dskdma_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SECT_BITS  = 8,
    parameter int SECT_SHIFT = 9,
    parameter int BUF_BYTES  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ctl_dir_write,
    input  logic                           ctl_drq_floppy,
    input  logic                           cnt_load,
    input  logic [SECT_BITS-1:0]           cnt_sectors,
    output logic [SECT_BITS-1:0]           sectors_left,
    input  logic                           addr_load,
    input  logic [ADDR_W-1:0]              addr_value,
    input  logic                           fdc_drq,
    input  logic [7:0]                     fdc_data,
    output logic                           bus_req,
    input  logic                           bus_gnt,
    output logic                           mem_valid,
    input  logic                           mem_ready,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [15:0]                    mem_wdata,
    output logic                           burst_done,
    output logic [$clog2(BUF_BYTES+1)-1:0] burst_words,
    output logic                           dma_err
);
    localparam int WW = $clog2(BUF_BYTES / 2);

    logic          take, soft_clr, fill_evt, rd_buf;
    logic [1:0]    clr_full;
    logic [WW-1:0] rd_word;
    fill_status_t  status;

    dskdma_capture #(
        .SECT_BITS (SECT_BITS),
        .SECT_SHIFT(SECT_SHIFT)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .drq         (fdc_drq),
        .drq_floppy  (ctl_drq_floppy),
        .dir_write   (ctl_dir_write),
        .cnt_load    (cnt_load),
        .cnt_sectors (cnt_sectors),
        .take        (take),
        .soft_clr    (soft_clr),
        .sectors_left(sectors_left)
    );

    dskdma_bufbank #(
        .BUF_BYTES(BUF_BYTES)
    ) u_bufbank (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .din     (fdc_data),
        .soft_clr(soft_clr),
        .clr_full(clr_full),
        .rd_buf  (rd_buf),
        .rd_word (rd_word),
        .status  (status),
        .fill_evt(fill_evt),
        .rd_data (mem_wdata)
    );

    dskdma_burst #(
        .ADDR_W   (ADDR_W),
        .BUF_BYTES(BUF_BYTES)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .gnt       (bus_gnt),
        .enable    (~ctl_dir_write),
        .full      (status.full),
        .active    (status.active),
        .addr_load (addr_load),
        .addr_value(addr_value),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .rd_buf    (rd_buf),
        .rd_word   (rd_word),
        .clr_full  (clr_full),
        .done      (burst_done),
        .words     (burst_words)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_req <= 1'b0;
        else if (fill_evt)
            bus_req <= 1'b1;
        else if (bus_gnt)
            bus_req <= 1'b0;
    end

    assign dma_err = status.err;

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && !fill_evt) |=> !bus_req);

    // R11
    req_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(!ctl_dir_write));

endmodule

// File: tb/dskdma_engine_test.sv
module dskdma_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_dir_write = 1'b0;
    logic        ctl_drq_floppy = 1'b0;
    logic        cnt_load = 1'b0;
    logic [7:0]  cnt_sectors = '0;
    logic [7:0]  sectors_left;
    logic        addr_load = 1'b0;
    logic [23:0] addr_value = '0;
    logic        fdc_drq = 1'b0;
    logic [7:0]  fdc_data = '0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        burst_done;
    logic [4:0]  burst_words;
    logic        dma_err;

    always #5 clk = ~clk;

    dskdma_engine uut (
        .clk(clk), .rst(rst), .ctl_dir_write(ctl_dir_write), .ctl_drq_floppy(ctl_drq_floppy),
        .cnt_load(cnt_load), .cnt_sectors(cnt_sectors), .sectors_left(sectors_left),
        .addr_load(addr_load), .addr_value(addr_value), .fdc_drq(fdc_drq), .fdc_data(fdc_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .burst_done(burst_done),
        .burst_words(burst_words), .dma_err(dma_err)
    );

    int total = 0;
    int bad = 0;
    int dones_seen = 0;
    bit req_seen_w = 1'b0;
    bit bp_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [23:0] exp_addr = '0;
    logic [39:0] exp_q[$];
    int          done_q[$];
    logic [39:0] mon_e;
    int          mon_d;

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory back-pressure pattern, changed only at the rising edge
    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= bp_en ? lfsr[0] : 1'b1;
    end

    // monitor: pops expected words and burst sizes
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected memory word", {mem_addr, mem_wdata}, '0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == mon_e, "R6 word address/data", {mem_addr, mem_wdata}, mon_e);
                end
            end
            if (burst_done) begin
                dones_seen++;
                if (done_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done pulse", 40'(burst_words), '0);
                end else begin
                    mon_d = done_q.pop_front();
                    chk(burst_words == 5'(mon_d), "R9 burst word count", 40'(burst_words), 40'(mon_d));
                    chk(exp_q.size() == 0, "R7 all expected words written", 40'(exp_q.size()), '0);
                end
            end
            if (ctl_dir_write && bus_req)
                req_seen_w = 1'b1;
        end
    end

    task automatic feed(input logic [7:0] b);
        @(negedge clk); fdc_drq = 1'b1; fdc_data = b;
        @(negedge clk); fdc_drq = 1'b0;
    endtask

    task automatic feed_hold(input logic [7:0] b, input int n);
        @(negedge clk); fdc_drq = 1'b1; fdc_data = b;
        repeat (n) @(negedge clk);
        fdc_drq = 1'b0;
    endtask

    task automatic feed_run(input logic [7:0] base, input int n);
        for (int i = 0; i < n; i++) feed(base + 8'(i));
    endtask

    task automatic expect_buf(input logic [7:0] base);
        logic [7:0] hi, lo;
        for (int i = 0; i < 8; i++) begin
            hi = base + 8'(2 * i);
            lo = hi + 8'd1;
            exp_q.push_back({exp_addr, hi, lo});
            exp_addr = exp_addr + 24'd2;
        end
    endtask

    task automatic wait_done(input int d0);
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (dones_seen != d0) break;
        end
        if (dones_seen == d0) chk(1'b0, "R9 done pulse missing", '0, 40'd1);
        @(negedge clk);
    endtask

    task automatic grant(input int nwords);
        int d0;
        done_q.push_back(nwords);
        d0 = dones_seen;
        @(negedge clk); bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0;
        wait_done(d0);
    endtask

    task automatic load_cnt(input logic [7:0] s);
        @(negedge clk); cnt_load = 1'b1; cnt_sectors = s;
        @(negedge clk); cnt_load = 1'b0;
    endtask

    task automatic load_addr(input logic [23:0] a);
        @(negedge clk); addr_load = 1'b1; addr_value = a;
        @(negedge clk); addr_load = 1'b0;
        exp_addr = a & ~24'd1;
    endtask

    task automatic dir_flip_reset;
        @(negedge clk); ctl_dir_write = 1'b1;
        @(negedge clk); ctl_dir_write = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 1'b0, "R5 reset request", 40'(bus_req), '0);
        chk(dma_err == 1'b0, "R4 reset error", 40'(dma_err), '0);
        chk(mem_valid == 1'b0, "R9 reset valid", 40'(mem_valid), '0);
        chk(sectors_left == 8'd0, "R2 reset budget", 40'(sectors_left), '0);

        ctl_drq_floppy = 1'b1;
        load_addr(24'h001001);

        // R1: zero budget ignores requests
        feed_run(8'hEE, 3);
        load_cnt(8'd1);
        chk(sectors_left == 8'd1, "R2 budget load", 40'(sectors_left), 40'd1);

        // R1: other request source ignored
        ctl_drq_floppy = 1'b0;
        feed_run(8'hDD, 3);
        ctl_drq_floppy = 1'b1;

        // R1: long request gives one byte; R3 ordering; R6 big-endian words
        feed_hold(8'h10, 5);
        feed_run(8'h11, 15);
        chk(bus_req == 1'b1, "R5 request after fill", 40'(bus_req), 40'd1);
        chk(dma_err == 1'b0, "R3 single fill no error", 40'(dma_err), '0);
        expect_buf(8'h10);
        grant(8);
        chk(bus_req == 1'b0, "R5 request dropped by grant", 40'(bus_req), '0);

        // R8: grant with older buffer empty writes nothing, partial data kept
        feed_run(8'h40, 5);
        grant(0);
        feed_run(8'h45, 11);
        expect_buf(8'h40);
        grant(8);

        // R4 overrun, dropped bytes, sticky; R7 double burst; R9 back-pressure
        bp_en = 1'b1;
        feed_run(8'h60, 16);
        feed_run(8'h80, 16);
        chk(dma_err == 1'b1, "R4 overrun flag", 40'(dma_err), 40'd1);
        feed_run(8'hF0, 2);
        expect_buf(8'h60);
        expect_buf(8'h80);
        grant(16);
        chk(dma_err == 1'b1, "R4 error sticky", 40'(dma_err), 40'd1);
        feed_run(8'hA0, 16);
        expect_buf(8'hA0);
        grant(8);
        bp_en = 1'b0;
        repeat (2) @(negedge clk);

        // R11: direction change clears state
        dir_flip_reset();
        chk(dma_err == 1'b0, "R11 error cleared", 40'(dma_err), '0);
        chk(sectors_left == 8'd0, "R11 budget cleared", 40'(sectors_left), '0);

        // R10: fill completes on the final beat of the older buffer
        load_cnt(8'd2);
        feed_run(8'h20, 16);
        feed_run(8'h30, 15);
        expect_buf(8'h20);
        done_q.push_back(8);
        d0 = dones_seen;
        @(negedge clk); bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0;
        repeat (7) @(negedge clk);
        fdc_drq = 1'b1; fdc_data = 8'h3F;
        @(negedge clk); fdc_drq = 1'b0;
        wait_done(d0);
        chk(dma_err == 1'b0, "R10 no error on same-cycle free", 40'(dma_err), '0);
        chk(bus_req == 1'b1, "R10 new request", 40'(bus_req), 40'd1);
        expect_buf(8'h30);
        grant(8);
        chk(dma_err == 1'b0, "R10 error stays clear", 40'(dma_err), '0);

        // R11: write direction idles
        @(negedge clk); ctl_dir_write = 1'b1;
        load_cnt(8'd1);
        feed_run(8'h50, 16);
        d0 = dones_seen;
        @(negedge clk); bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0;
        repeat (10) @(negedge clk);
        chk(bus_req == 1'b0, "R11 no request in write mode", 40'(bus_req), '0);
        chk(req_seen_w == 1'b0, "R11 request never seen in write mode", 40'(req_seen_w), '0);
        chk(dones_seen == d0, "R11 grant ignored in write mode", 40'(dones_seen), 40'(d0));
        @(negedge clk); ctl_dir_write = 1'b0;
        @(negedge clk);

        // R1/R2: budget exhaustion over one sector
        load_cnt(8'd1);
        for (int blk = 0; blk < 32; blk++) begin
            feed_run(8'(blk * 16), 16);
            if (blk == 0)
                chk(sectors_left == 8'd1, "R1 rounded-up sectors", 40'(sectors_left), 40'd1);
            if (blk == 30)
                chk(sectors_left == 8'd1, "R1 sectors near end", 40'(sectors_left), 40'd1);
            expect_buf(8'(blk * 16));
            grant(8);
        end
        chk(sectors_left == 8'd0, "R1 budget exhausted", 40'(sectors_left), '0);
        feed_run(8'h77, 3);
        load_cnt(8'd1);
        feed_run(8'hC0, 16);
        expect_buf(8'hC0);
        grant(8);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 no words left over", 40'(exp_q.size()), '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule